// File: doc/BRIEF.md
# Programmable Memory Access Channel

This block is one memory access channel of a DSP core. The core sets it up through a control register port and then moves data through a data register port. Setup takes two control writes: the first holds a target address and the second holds a mode word. The next data-port access (read or write) binds that address and mode pair to the channel's read descriptor or to its write descriptor, depending on the direction of the access. Because the two descriptors are kept apart, one channel can fetch from one region and store to a completely different one.

Every data access served by a bound descriptor issues one request to an external word memory in the same cycle. Then, on the clock edge, it advances that descriptor's address. The step is set by the mode word. It can be a power-of-two displacement in either direction, a custom displacement loaded by a control write, or a bitmap pattern that walks word pairs laid out 32 words apart. A write can optionally protect every destination nibble whose incoming nibble is zero, by driving a per-nibble write enable. Control reads return the address of the most recently used descriptor after its step.

Top module: `pmac_channel`

## Requirements
- R1: After reset both descriptors are unbound, no setup pair is pending, the next control write is taken as an address, and `ctl_rdata` is 0.
- R2: The control write taken as an address is followed by one taken as a mode word, which makes the pair pending. The next data access binds the pending pair to the write side (if `dat_wr`) or the read side (if `dat_rd`), and that same access uses the pending address. A control write made while a pair is pending but unused starts a new address.
- R3: Read and write descriptors hold separate addresses and modes. An access on one side never changes the other side's address.
- R4: Mode bits [13:11] select the step: codes 0 to 6 step by 0, 1, 2, 4, 8, 16, 32 words. Mode bit 15 set subtracts the step and clear adds it. Addresses wrap modulo 2^AW.
- R5: With code 7, the first control write after the binding access loads that side's custom step, and it is not taken as an address. The custom step is 0 from binding until it is loaded.
- R6: Mode bit 10 (overwrite) makes a write drive `mem_nib_we[i]` high only where data nibble i is non-zero. Without it, writes drive all ones. Reads always drive zeros.
- R7: Mode bit 14 (bitmap) steps an even address by +1 and an odd address by +31. It ignores the step code and bit 15.
- R8: `ctl_rdata` returns the stepped address of the descriptor used by the most recent served access.
- R9: `mem_bus` is mode bit 4 and `mem_page` is mode bits [3:0] of the descriptor used by the access.
- R10: A data access on a side with no bound descriptor and no pending pair raises no `mem_req` and changes no state.
- R11: With `dat_rd` and `dat_wr` both high, only the write is served. A control write in the same cycle as any data access is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | AW | Control write word (address, mode or custom step) |
| ctl_rdata | output | AW | Address after the most recent served access |
| dat_rd | input | 1 | Data register read strobe |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | DW | Data register write word |
| dat_rdata | output | DW | Data register read word (from memory) |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_bus | output | 1 | Bus select from the mode word (0 ROM, 1 RAM) |
| mem_page | output | PW | Page from the mode word |
| mem_addr | output | AW | Word address of the request |
| mem_wdata | output | DW | Write word |
| mem_nib_we | output | DW/4 | Per-nibble write enable |
| mem_rdata | input | DW | Memory read word |

## Verification
On every cycle the assertions check that a request only appears with a data strobe, that reads never enable nibbles, that a dual strobe is served as a write, that an idle descriptor keeps its address, that bitmap stepping from an even address adds one, and that the setup sequencer moves from address to mode to pending as required. Effects that span several operations can only be shown by the bench's scenarios. These include how descriptors stay separate across rebinding, the custom step loaded after binding, wrap-around in both directions, and the readback after a mix of read and write traffic.

// File: rtl/pmac_pkg.sv
package pmac_pkg;

   localparam int MODE_W   = 16;
   localparam int CODE_W   = 3;
   localparam int PAGE_W   = 4;
   localparam int CUSTOM_C = 7;

   // decoded mode word: positions are decoded here only
   typedef struct packed {
      logic              dec;
      logic              bmp;
      logic [CODE_W-1:0] code;
      logic              ovw;
      logic              bus;
      logic [PAGE_W-1:0] page;
   } mode_t;

   function automatic mode_t mode_decode(input logic [MODE_W-1:0] w);
      mode_t m;
      m.dec  = w[15];
      m.bmp  = w[14];
      m.code = w[13:11];
      m.ovw  = w[10];
      m.bus  = w[4];
      m.page = w[3:0];
      return m;
   endfunction

   typedef enum logic {
      SIDE_RD = 1'b0,
      SIDE_WR = 1'b1
   } side_e;

endpackage

// File: rtl/pmac_stepper.sv
module pmac_stepper
   import pmac_pkg::*;
#(
   parameter int AW        = 16,
   parameter int PAIR_SKIP = 31
) (
   input  logic [AW-1:0] cur_addr,
   input  mode_t         mode,
   input  logic [AW-1:0] custom,
   output logic [AW-1:0] nxt_addr
);
   localparam logic [AW-1:0] ONE  = {{(AW-1){1'b0}}, 1'b1};
   localparam logic [AW-1:0] SKIP = AW'(PAIR_SKIP);

   logic [AW-1:0] disp;

   always_comb begin
      if (mode.code == '0)
         disp = '0;
      else if (mode.code == CODE_W'(CUSTOM_C))
         disp = custom;
      else
         disp = ONE << (mode.code - CODE_W'(1));
   end

   always_comb begin
      if (mode.bmp)
         nxt_addr = cur_addr + (cur_addr[0] ? SKIP : ONE);
      else if (mode.dec)
         nxt_addr = cur_addr - disp;
      else
         nxt_addr = cur_addr + disp;
   end

endmodule

// File: rtl/pmac_ctl.sv
module pmac_ctl
   import pmac_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_wr,
   input  logic [AW-1:0] ctl_wdata,
   input  logic          acc_any,
   input  side_e         acc_side,
   output logic          pend,
   output logic [AW-1:0] pend_addr,
   output mode_t         pend_mode,
   output logic          cust_wr,
   output side_e         cust_side
);
   logic  phase_q;   // 0: next write is address, 1: next is mode
   logic  cwait_q;
   side_e cside_q;
   logic  ctl_eff;
   logic  bind_fire;

   assign ctl_eff   = ctl_wr && !acc_any;
   assign bind_fire = pend && acc_any;
   assign cust_wr   = ctl_eff && cwait_q;
   assign cust_side = cside_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q   <= 1'b0;
         pend      <= 1'b0;
         cwait_q   <= 1'b0;
         cside_q   <= SIDE_RD;
         pend_addr <= '0;
         pend_mode <= '0;
      end else begin
         if (bind_fire) begin
            pend <= 1'b0;
            if (pend_mode.code == CODE_W'(CUSTOM_C)) begin
               cwait_q <= 1'b1;
               cside_q <= acc_side;
            end
         end
         if (ctl_eff) begin
            if (cwait_q) begin
               cwait_q <= 1'b0;
            end else if (!phase_q) begin
               pend_addr <= ctl_wdata;
               phase_q   <= 1'b1;
               pend      <= 1'b0;
            end else begin
               pend_mode <= mode_decode(ctl_wdata[MODE_W-1:0]);
               phase_q   <= 1'b0;
               pend      <= 1'b1;
            end
         end
      end
   end

   a_r2_mode_makes_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_eff && !cwait_q && phase_q) |=> pend);

   a_r2_addr_then_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_eff && !cwait_q && !phase_q) |=> (phase_q && !pend));

   a_r5_wait_after_custom_bind: assert property (@(posedge clk) disable iff (!rst_n)
      (bind_fire && pend_mode.code == CODE_W'(CUSTOM_C)) |=> cwait_q);

endmodule

// File: rtl/pmac_desc.sv
module pmac_desc
   import pmac_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bind_in,
   input  logic          acc,
   input  logic [AW-1:0] pend_addr,
   input  mode_t         pend_mode,
   input  logic          cust_wr,
   input  logic [AW-1:0] cust_val,
   output logic          valid,
   output logic          served,
   output logic [AW-1:0] eff_addr,
   output mode_t         eff_mode,
   output logic [AW-1:0] nxt_addr
);
   logic [AW-1:0] addr_q;
   mode_t         mode_q;
   logic [AW-1:0] cust_q;
   logic [AW-1:0] eff_cust;

   assign served   = bind_in || (acc && valid);
   assign eff_addr = bind_in ? pend_addr : addr_q;
   assign eff_mode = bind_in ? pend_mode : mode_q;
   assign eff_cust = bind_in ? '0 : cust_q;

   pmac_stepper #(.AW(AW)) u_step (
      .cur_addr (eff_addr),
      .mode     (eff_mode),
      .custom   (eff_cust),
      .nxt_addr (nxt_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid  <= 1'b0;
         addr_q <= '0;
         mode_q <= '0;
         cust_q <= '0;
      end else begin
         if (bind_in) begin
            valid  <= 1'b1;
            mode_q <= pend_mode;
            cust_q <= '0;
         end else if (cust_wr) begin
            cust_q <= cust_val;
         end
         if (served)
            addr_q <= nxt_addr;
      end
   end

   a_r10_idle_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
      !served |=> $stable(addr_q));

   a_r7_bitmap_even_step: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && valid && !bind_in && mode_q.bmp && !addr_q[0])
      |=> (addr_q == $past(addr_q) + {{(AW-1){1'b0}}, 1'b1}));

endmodule

// File: rtl/pmac_channel.sv
module pmac_channel
   import pmac_pkg::*;
#(
   parameter int AW    = 16,
   parameter int DW    = 16,
   parameter int NIB_W = 4,
   localparam int NIBS = DW / NIB_W,
   localparam int PW   = PAGE_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ctl_wr,
   input  logic [AW-1:0]   ctl_wdata,
   output logic [AW-1:0]   ctl_rdata,
   input  logic            dat_rd,
   input  logic            dat_wr,
   input  logic [DW-1:0]   dat_wdata,
   output logic [DW-1:0]   dat_rdata,
   output logic            mem_req,
   output logic            mem_we,
   output logic            mem_bus,
   output logic [PW-1:0]   mem_page,
   output logic [AW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   output logic [NIBS-1:0] mem_nib_we,
   input  logic [DW-1:0]   mem_rdata
);
   if (AW < MODE_W) begin : g_chk_aw
      $error("AW must hold a full mode word");
   end
   if (DW % NIB_W != 0) begin : g_chk_nib
      $error("DW must be a multiple of NIB_W");
   end

   logic          acc_any;
   side_e         acc_side;
   logic [1:0]    side_acc;
   logic          pend;
   logic [AW-1:0] pend_addr;
   mode_t         pend_mode;
   logic          cust_wr;
   side_e         cust_side;
   logic [1:0]    valid;
   logic [1:0]    served;
   logic [AW-1:0] eff_addr [2];
   mode_t         eff_mode [2];
   logic [AW-1:0] nxt_addr [2];
   logic [NIBS-1:0] nz_mask;
   logic [AW-1:0] last_q;
   mode_t         use_mode;

   // write wins over read on a dual strobe
   assign acc_any     = dat_rd || dat_wr;
   assign acc_side    = dat_wr ? SIDE_WR : SIDE_RD;
   assign side_acc[0] = dat_rd && !dat_wr;
   assign side_acc[1] = dat_wr;

   pmac_ctl #(.AW(AW)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .ctl_wdata (ctl_wdata),
      .acc_any   (acc_any),
      .acc_side  (acc_side),
      .pend      (pend),
      .pend_addr (pend_addr),
      .pend_mode (pend_mode),
      .cust_wr   (cust_wr),
      .cust_side (cust_side)
   );

   for (genvar s = 0; s < 2; s++) begin : g_side
      pmac_desc #(.AW(AW)) u_desc (
         .clk       (clk),
         .rst_n     (rst_n),
         .bind_in   (pend && side_acc[s]),
         .acc       (side_acc[s]),
         .pend_addr (pend_addr),
         .pend_mode (pend_mode),
         .cust_wr   (cust_wr && (cust_side == side_e'(s))),
         .cust_val  (ctl_wdata),
         .valid     (valid[s]),
         .served    (served[s]),
         .eff_addr  (eff_addr[s]),
         .eff_mode  (eff_mode[s]),
         .nxt_addr  (nxt_addr[s])
      );
   end

   for (genvar n = 0; n < NIBS; n++) begin : g_nib
      assign nz_mask[n] = |dat_wdata[n*NIB_W +: NIB_W];
   end

   assign use_mode  = eff_mode[acc_side];
   assign mem_req   = |served;
   assign mem_we    = served[SIDE_WR];
   assign mem_addr  = eff_addr[acc_side];
   assign mem_bus   = use_mode.bus;
   assign mem_page  = use_mode.page;
   assign mem_wdata = dat_wdata;
   assign dat_rdata = mem_rdata;

   always_comb begin
      if (!served[SIDE_WR])
         mem_nib_we = '0;
      else if (use_mode.ovw)
         mem_nib_we = nz_mask;
      else
         mem_nib_we = '1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         last_q <= '0;
      else if (mem_req)
         last_q <= nxt_addr[acc_side];
   end
   assign ctl_rdata = last_q;

   a_r10_req_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (dat_rd || dat_wr));

   a_r6_read_no_nibble: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (mem_nib_we == '0));

   a_r11_dual_is_write: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && dat_rd && dat_wr) |-> mem_we);

   a_r8_idle_keeps_readback: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req |=> $stable(ctl_rdata));

   a_r3_one_side_served: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(served) <= 1);

endmodule

// File: tb/test_pmac_channel.sv
module test_pmac_channel;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [15:0] ctl_wdata = '0;
   logic [15:0] ctl_rdata;
   logic        dat_rd = 1'b0, dat_wr = 1'b0;
   logic [15:0] dat_wdata = '0, dat_rdata;
   logic        mem_req, mem_we, mem_bus;
   logic [3:0]  mem_page, mem_nib_we;
   logic [15:0] mem_addr, mem_wdata;
   logic [15:0] mem_rdata = 16'h5a5a;

   int checks = 0, errors = 0;

   // model state
   bit          m_phase, m_pend, m_cwait, m_cside;
   logic [15:0] m_paddr, m_pmode, m_last;
   bit          m_val [2];
   logic [15:0] m_addr [2], m_mode [2], m_cust [2];

   always #(CLK_P/2) clk = ~clk;

   pmac_channel i_pmac_channel (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .dat_rd(dat_rd), .dat_wr(dat_wr),
      .dat_wdata(dat_wdata), .dat_rdata(dat_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_bus(mem_bus), .mem_page(mem_page),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_nib_we(mem_nib_we),
      .mem_rdata(mem_rdata));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] f_step(input logic [15:0] a, input logic [15:0] m,
                                          input logic [15:0] c);
      logic [15:0] d;
      if (m[14]) return a[0] ? a + 16'd31 : a + 16'd1;
      case (m[13:11])
         3'd0:    d = 16'd0;
         3'd7:    d = c;
         default: d = 16'd1 << (m[13:11] - 3'd1);
      endcase
      return m[15] ? a - d : a + d;
   endfunction

   function automatic string f_tag(input logic [15:0] m);
      if (m[14]) return "R7 bitmap step";
      if (m[13:11] == 3'd7) return "R5 custom step";
      return "R4 coded step";
   endfunction

   task automatic model_reset();
      m_phase = 0; m_pend = 0; m_cwait = 0; m_cside = 0; m_last = '0;
      m_paddr = '0; m_pmode = '0;
      for (int s = 0; s < 2; s++) begin
         m_val[s] = 0; m_addr[s] = '0; m_mode[s] = '0; m_cust[s] = '0;
      end
   endtask

   task automatic cyc(input bit cw, input logic [15:0] cd, input bit dr,
                      input bit dw, input logic [15:0] wd);
      bit acc, side, bnd, srv;
      logic [15:0] ea, em, ec, nxt;
      logic [3:0] enib;
      @(negedge clk);
      ctl_wr = cw; ctl_wdata = cd; dat_rd = dr; dat_wr = dw; dat_wdata = wd;
      acc  = dr || dw;
      side = dw;
      bnd  = acc && m_pend;
      srv  = bnd || (acc && m_val[side]);
      ea   = bnd ? m_paddr : m_addr[side];
      em   = bnd ? m_pmode : m_mode[side];
      ec   = bnd ? 16'd0 : m_cust[side];
      enib = '0;
      if (srv && dw) begin
         for (int n = 0; n < 4; n++)
            enib[n] = em[10] ? (wd[n*4 +: 4] != 4'd0) : 1'b1;
      end
      #1;
      chk(srv ? "R2 request" : "R10 unbound no request", {31'd0, mem_req}, {31'd0, srv});
      if (srv) begin
         chk(dr && dw ? "R11 dual strobe write" : "R3 direction", {31'd0, mem_we}, {31'd0, side});
         chk(bnd ? "R2 bind address" : "R3 side address", {16'd0, mem_addr}, {16'd0, ea});
         chk("R9 bus page", {27'd0, mem_bus, mem_page}, {27'd0, em[4], em[3:0]});
         chk("R6 nibble enable", {28'd0, mem_nib_we}, {28'd0, enib});
      end
      nxt = f_step(ea, em, ec);
      @(posedge clk);
      if (srv) begin
         m_addr[side] = nxt;
         m_last = nxt;
         if (bnd) begin
            m_val[side] = 1; m_mode[side] = em; m_cust[side] = '0; m_pend = 0;
            if (em[13:11] == 3'd7) begin m_cwait = 1; m_cside = side; end
         end
      end
      if (cw && !acc) begin
         if (m_cwait) begin m_cust[m_cside] = cd; m_cwait = 0; end
         else if (!m_phase) begin m_paddr = cd; m_phase = 1; m_pend = 0; end
         else begin m_pmode = cd; m_phase = 0; m_pend = 1; end
      end
      #1;
      chk(srv ? f_tag(em) : "R8 readback held", {16'd0, ctl_rdata}, {16'd0, m_last});
      ctl_wr = 0; dat_rd = 0; dat_wr = 0;
   endtask

   task automatic prog(input logic [15:0] a, input logic [15:0] m);
      cyc(1, a, 0, 0, 0);
      cyc(1, m, 0, 0, 0);
   endtask

   initial begin
      #(CLK_P * 200000);
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int unsigned seed;
      int unsigned r;
      seed = 32'd1234;
      void'($urandom(seed));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      chk("R1 reset readback", {16'd0, ctl_rdata}, 32'd0);
      chk("R1 reset no request", {31'd0, mem_req}, 32'd0);
      // R10: unbound accesses
      cyc(0, 0, 1, 0, 0);
      cyc(0, 0, 0, 1, 16'hffff);
      // R7/R6: write side, bitmap + overwrite, RAM page 8
      prog(16'h0100, 16'h4418);
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 16'h0f30);
      // R4: read side, code 3 decrement, ROM page 2; wraps below zero
      prog(16'h0006, 16'h9802);
      for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 0);
      // R3: write side still continues its own sequence
      cyc(0, 0, 0, 1, 16'h1234);
      // R2: control write while pending restarts address
      prog(16'h0300, 16'h0800);
      prog(16'h0400, 16'h1000);
      cyc(0, 0, 1, 0, 0);
      // R5: custom step on write side
      prog(16'hfff0, 16'h3800);
      cyc(0, 0, 0, 1, 16'h0001);
      cyc(0, 0, 0, 1, 16'h0002);
      cyc(1, 16'd5, 0, 0, 0);
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 16'h00a0);
      // R11: dual strobe and control write during access
      cyc(0, 0, 1, 1, 16'h0ff0);
      cyc(1, 16'hbeef, 1, 0, 0);
      cyc(1, 16'h0200, 0, 0, 0);
      cyc(1, 16'hc000, 1, 0, 0);
      cyc(1, 16'h0000, 0, 0, 0);
      // random mix
      for (int i = 0; i < 4000; i++) begin
         r = $urandom_range(0, 9);
         if (r < 3) cyc(1, 16'($urandom()), 0, 0, 0);
         else if (r < 6) cyc(0, 0, 1, 0, 0);
         else if (r < 9) cyc(0, 0, 0, 1, 16'($urandom()));
         else cyc($urandom_range(0, 1) == 1, 16'($urandom()), 1, 1, 16'($urandom()));
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule